// File: doc/BRIEF.md
# Two-Speed Clock Start-Up Controller

This block picks the system clock after a reset or a wake from sleep. When the primary oscillator is one of the crystal types, it does not make the core wait. The core starts at once on the internal oscillator. A start-up counter counts primary-oscillator edges, and in PLL mode a lock delay follows the count. When both have finished, the system clock moves to the primary source. A status output then reads 1.

The state machine runs on the internal clock. It has five states:
- `ST_PWRT` waits for the power-up timer.
- `ST_INT_RUN` runs the core on the internal clock while the counter runs.
- `ST_HOLD` keeps the core stopped while the counter runs. It is used when the feature is disabled.
- `ST_PRI_RUN` runs the core on the primary clock.
- `ST_SLEEP` stops all clocks.

The transitions are:
- `ST_PWRT`→(start state) on `pwrt_done`.
- `ST_SLEEP`→(start state) on `wake_evt`, once the counter has drained.
- `ST_INT_RUN`→`ST_SLEEP` on `sleep_req`.
- `ST_INT_RUN`→`ST_PRI_RUN` when the primary source is ready.
- `ST_HOLD`→`ST_PRI_RUN` when the primary source is ready.
- `ST_PRI_RUN`→`ST_SLEEP` on `sleep_req`.

The start state is `ST_PRI_RUN` for a non-crystal mode. For a crystal mode it is `ST_INT_RUN` when the feature is enabled and `ST_HOLD` when it is not.

Each clock source has its own enable. Each enable is updated on the falling edge of its own clock. Each enable also waits until it sees, through a synchroniser, that the other enable is off. This makes the clock handover free of glitches.

Top module: `twospeed_clk_ctl`

## Requirements
- R1: While reset is asserted, `cpu_run`, `pri_active` and `int_freq_sel` are all 0.
- R2: After reset, and until `pwrt_done` is seen, no clock source is enabled (`cpu_run` = 0).
- R3: With the feature enabled and a crystal mode (`cfg_pri_mode` 0 = low-power crystal, 1 = crystal, 2 = high-speed crystal, 3 = high-speed crystal with PLL), the core is clocked from the internal oscillator within 3 cycles of the start event. `pri_active` stays 0 until the switch.
- R4: In crystal modes 0 to 2, `pri_active` rises only after at least OST_CYCLES primary-clock periods have been counted from the start event. It rises within a few synchroniser cycles of that point.
- R5: In mode 3, a further PLL_LOCK_CYCLES internal-clock cycles are added after the count before the switch.
- R6: Modes 4 to 7 are non-crystal. They select the primary source directly, with no start-up count, whatever the enable bit is.
- R7: With the feature disabled and a crystal mode, the core receives no clock until the primary source takes over.
- R8: A sleep request stops every clock. It does so both before and after the switch. While asleep, the block never switches to the primary source.
- R9: `int_freq_sel` is cleared by reset, loaded by a write strobe, and kept through sleep and wake.
- R10: The internal and primary clock enables are never on together.
- R11: A wake event reselects the internal clock and restarts the start-up count from zero.
- R12: The enable bit and the mode are sampled only at the start event. Later changes have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator clock; also clocks the control logic |
| pri_clk | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrt_done | input | 1 | Power-up timer has expired |
| cfg_twospeed_en | input | 1 | Enables starting on the internal clock |
| cfg_pri_mode | input | 3 | Primary oscillator mode (0 to 3 crystal, 3 with PLL, 4 to 7 other) |
| ircf_wr | input | 1 | Write strobe for the internal frequency select |
| ircf_wdata | input | 3 | New internal frequency select value |
| sleep_req | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | Wake-from-sleep event |
| sys_clk | output | 1 | Glitch-free system clock |
| cpu_run | output | 1 | A clock source is currently driving `sys_clk` |
| pri_active | output | 1 | The primary oscillator is supplying the system clock |
| int_freq_sel | output | 3 | Current internal frequency select |

## Verification
The bench builds the block with OST_CYCLES = 16 and PLL_LOCK_CYCLES = 20. With these values every switch completes within a few dozen cycles. That makes it cheap to sweep all eight primary modes against both values of the enable bit.

Each switch time is checked against a window computed in the bench from the two clock periods, the count and the lock delay. The primary clock is offset so that its edges never meet the internal clock's edges.

A dedicated sequence covers the following:
- a sleep before the count expires;
- a configuration change while the count runs;
- a wake that restarts the count;
- a sleep taken from primary run;
- the frequency select field across sleep and reset.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [2:0] {
        ST_PWRT    = 3'd0,
        ST_INT_RUN = 3'd1,
        ST_HOLD    = 3'd2,
        ST_PRI_RUN = 3'd3,
        ST_SLEEP   = 3'd4
    } tss_state_e;

    localparam logic [2:0] PM_HSPLL = 3'd3;

    function automatic logic is_crystal(input logic [2:0] mode);
        return (mode <= 3'd3);
    endfunction

endpackage

// File: rtl/tss_ost_counter.sv
module tss_ost_counter #(
    parameter int OST_CYCLES = 1024
) (
    input  logic pri_clk,
    input  logic int_clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic done_o
);
    localparam int CW = $clog2(OST_CYCLES + 1);

    logic [1:0]    arm_sync;
    logic [CW-1:0] cnt_q;
    logic          done_p;
    logic [1:0]    done_sync;

    assign done_p = (cnt_q == CW'(OST_CYCLES));

    always_ff @(posedge pri_clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_sync <= '0;
        end else begin
            arm_sync <= {arm_sync[0], arm_i};
        end
    end

    always_ff @(posedge pri_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm_sync[1]) begin
            cnt_q <= '0;
        end else if (!done_p) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) begin
            done_sync <= '0;
        end else begin
            done_sync <= {done_sync[0], done_p};
        end
    end

    assign done_o = done_sync[1];

    // Counting advances by exactly one primary edge while armed (R4)
    assert_ost_step_R4: assert property (@(posedge pri_clk) disable iff (!rst_n)
        (arm_sync[1] && !done_p) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    // Disarming clears the count so a later wake restarts it (R11)
    assert_ost_clear_R11: assert property (@(posedge pri_clk) disable iff (!rst_n)
        !arm_sync[1] |=> (cnt_q == '0));

endmodule

// File: rtl/tss_clk_switch.sv
module tss_clk_switch (
    input  logic int_clk,
    input  logic pri_clk,
    input  logic rst_n,
    input  logic sel_int_i,
    input  logic sel_pri_i,
    output logic sys_clk_o,
    output logic int_on_o,
    output logic pri_on_o
);
    logic [1:0] sel_pri_sync;
    logic [1:0] int_seen;
    logic [1:0] pri_seen;
    logic       en_int_q;
    logic       en_pri_q;

    always_ff @(negedge pri_clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_pri_sync <= '0;
            int_seen     <= '0;
            en_pri_q     <= 1'b0;
        end else begin
            sel_pri_sync <= {sel_pri_sync[0], sel_pri_i};
            int_seen     <= {int_seen[0], en_int_q};
            en_pri_q     <= sel_pri_sync[1] & ~int_seen[1];
        end
    end

    always_ff @(negedge int_clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_seen <= '0;
            en_int_q <= 1'b0;
        end else begin
            pri_seen <= {pri_seen[0], en_pri_q};
            en_int_q <= sel_int_i & ~pri_seen[1];
        end
    end

    assign sys_clk_o = (int_clk & en_int_q) | (pri_clk & en_pri_q);
    assign int_on_o  = en_int_q;
    assign pri_on_o  = en_pri_q;

    // The two source enables never overlap (R10)
    assert_excl_R10: assert property (@(posedge int_clk) disable iff (!rst_n)
        $onehot0({en_int_q, en_pri_q}));

endmodule

// File: rtl/tss_fsm.sv
module tss_fsm
    import tss_pkg::*;
#(
    parameter int PLL_LOCK_CYCLES = 80000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwrt_done_i,
    input  logic       cfg_en_i,
    input  logic [2:0] cfg_mode_i,
    input  logic       sleep_req_i,
    input  logic       wake_evt_i,
    input  logic       ost_done_i,
    output logic       ost_arm_o,
    output logic       sel_int_o,
    output logic       sel_pri_o
);
    localparam int PW = $clog2(PLL_LOCK_CYCLES + 1);

    tss_state_e    state_q, state_d, start_st;
    logic          start_evt;
    logic          pll_q;
    logic [PW-1:0] pll_cnt_q;
    logic          pll_ok;
    logic          pri_ready;
    logic          counting;

    always_comb begin
        if (!is_crystal(cfg_mode_i)) begin
            start_st = ST_PRI_RUN;
        end else if (cfg_en_i) begin
            start_st = ST_INT_RUN;
        end else begin
            start_st = ST_HOLD;
        end
    end

    assign start_evt = ((state_q == ST_PWRT) && pwrt_done_i) ||
                       ((state_q == ST_SLEEP) && wake_evt_i && !ost_done_i);
    assign counting  = (state_q == ST_INT_RUN) || (state_q == ST_HOLD);
    assign pll_ok    = !pll_q || (pll_cnt_q == PW'(PLL_LOCK_CYCLES));
    assign pri_ready = ost_done_i && pll_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWRT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRT:    if (pwrt_done_i) state_d = start_st;
            ST_INT_RUN: begin
                if (sleep_req_i)    state_d = ST_SLEEP;
                else if (pri_ready) state_d = ST_PRI_RUN;
            end
            ST_HOLD:    if (pri_ready) state_d = ST_PRI_RUN;
            ST_PRI_RUN: if (sleep_req_i) state_d = ST_SLEEP;
            ST_SLEEP:   if (wake_evt_i && !ost_done_i) state_d = start_st;
            default:    state_d = ST_PWRT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_q     <= 1'b0;
            pll_cnt_q <= '0;
        end else begin
            if (start_evt) begin
                pll_q <= (cfg_mode_i == PM_HSPLL);
            end
            if (!counting) begin
                pll_cnt_q <= '0;
            end else if (ost_done_i && pll_q && !pll_ok) begin
                pll_cnt_q <= pll_cnt_q + PW'(1);
            end
        end
    end

    always_comb begin
        ost_arm_o = counting;
        sel_int_o = (state_q == ST_INT_RUN);
        sel_pri_o = (state_q == ST_PRI_RUN);
    end

    // Nothing is selected before the power-up timer expires (R2)
    assert_pwrt_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PWRT) && !pwrt_done_i) |=> (!sel_int_o && !sel_pri_o));

    // Internal run persists until the start-up count completes (R4)
    assert_wait_ost_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_INT_RUN) && !ost_done_i && !sleep_req_i) |=> (state_q == ST_INT_RUN));

    // In PLL mode the hold continues while lock time is pending (R5)
    assert_pll_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOLD) && pll_q && (pll_cnt_q != PW'(PLL_LOCK_CYCLES))) |=> !sel_pri_o);

    // Sleep is left only through a wake event (R8)
    assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SLEEP) && !wake_evt_i) |=> ((state_q == ST_SLEEP) && !sel_pri_o));

endmodule

// File: rtl/twospeed_clk_ctl.sv
module twospeed_clk_ctl #(
    parameter int OST_CYCLES      = 1024,
    parameter int PLL_LOCK_CYCLES = 80000,
    parameter int FSEL_W          = 3
) (
    input  logic              int_clk,
    input  logic              pri_clk,
    input  logic              rst_n,
    input  logic              pwrt_done,
    input  logic              cfg_twospeed_en,
    input  logic [2:0]        cfg_pri_mode,
    input  logic              ircf_wr,
    input  logic [FSEL_W-1:0] ircf_wdata,
    input  logic              sleep_req,
    input  logic              wake_evt,
    output logic              sys_clk,
    output logic              cpu_run,
    output logic              pri_active,
    output logic [FSEL_W-1:0] int_freq_sel
);
    logic ost_arm, ost_done, sel_int, sel_pri, int_on, pri_on;
    logic [FSEL_W-1:0] fsel_q;

    tss_fsm #(.PLL_LOCK_CYCLES(PLL_LOCK_CYCLES)) u_fsm (
        .clk         (int_clk),
        .rst_n       (rst_n),
        .pwrt_done_i (pwrt_done),
        .cfg_en_i    (cfg_twospeed_en),
        .cfg_mode_i  (cfg_pri_mode),
        .sleep_req_i (sleep_req),
        .wake_evt_i  (wake_evt),
        .ost_done_i  (ost_done),
        .ost_arm_o   (ost_arm),
        .sel_int_o   (sel_int),
        .sel_pri_o   (sel_pri)
    );

    tss_ost_counter #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .pri_clk (pri_clk),
        .int_clk (int_clk),
        .rst_n   (rst_n),
        .arm_i   (ost_arm),
        .done_o  (ost_done)
    );

    tss_clk_switch u_sw (
        .int_clk   (int_clk),
        .pri_clk   (pri_clk),
        .rst_n     (rst_n),
        .sel_int_i (sel_int),
        .sel_pri_i (sel_pri),
        .sys_clk_o (sys_clk),
        .int_on_o  (int_on),
        .pri_on_o  (pri_on)
    );

    always_ff @(posedge int_clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_q <= '0;
        end else if (ircf_wr) begin
            fsel_q <= ircf_wdata;
        end
    end

    assign int_freq_sel = fsel_q;
    assign cpu_run      = int_on | pri_on;
    assign pri_active   = pri_on;

    // Frequency select changes only on a write strobe (R9)
    assert_fsel_hold_R9: assert property (@(posedge int_clk) disable iff (!rst_n)
        !ircf_wr |=> $stable(fsel_q));

endmodule

// File: tb/twospeed_clk_ctl_test.sv
`timescale 1ns/100ps
module twospeed_clk_ctl_test;
    localparam int OST = 16;
    localparam int PLL = 20;

    logic       int_clk = 1'b0;
    logic       pri_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrt_done = 1'b0;
    logic       cfg_en = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic       ircf_wr = 1'b0;
    logic [2:0] ircf_wdata = 3'd0;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       sys_clk, cpu_run, pri_active;
    logic [2:0] int_freq_sel;

    int checks = 0;
    int fails  = 0;

    twospeed_clk_ctl #(.OST_CYCLES(OST), .PLL_LOCK_CYCLES(PLL)) uut (
        .int_clk         (int_clk),
        .pri_clk         (pri_clk),
        .rst_n           (rst_n),
        .pwrt_done       (pwrt_done),
        .cfg_twospeed_en (cfg_en),
        .cfg_pri_mode    (cfg_mode),
        .ircf_wr         (ircf_wr),
        .ircf_wdata      (ircf_wdata),
        .sleep_req       (sleep_req),
        .wake_evt        (wake_evt),
        .sys_clk         (sys_clk),
        .cpu_run         (cpu_run),
        .pri_active      (pri_active),
        .int_freq_sel    (int_freq_sel)
    );

    always #5 int_clk = ~int_clk;
    initial begin
        #1.5;
        forever #4 pri_clk = ~pri_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge int_clk);
        #2;
    endtask

    // Earliest sample at which the count (and lock delay) can have completed
    function automatic int lo_bound(input bit pll);
        return (OST * 8 + 8 + 9) / 10 + (pll ? PLL : 0);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; pwrt_done = 1'b0; sleep_req = 1'b0; wake_evt = 1'b0; ircf_wr = 1'b0;
        repeat (3) tick();
        check(!cpu_run && !pri_active && int_freq_sel == 3'd0, "R1",
              {cpu_run, pri_active, int_freq_sel}, 0);
        rst_n = 1'b1;
    endtask

    task automatic measure(output int n, output bit cpu3, output bit run_int);
        n = 0; cpu3 = 1'b0; run_int = 1'b0;
        for (int i = 1; i <= 300; i++) begin
            tick();
            n = i;
            if (i == 3) cpu3 = cpu_run;
            if (cpu_run && !pri_active) run_int = 1'b1;
            if (pri_active) break;
        end
    endtask

    task automatic run_case(input int mode, input bit en);
        int n; bit c3; bit ri; int lo;
        cfg_mode = 3'(mode); cfg_en = en;
        do_reset();
        repeat (4) tick();
        check(!cpu_run && !pri_active, "R2", cpu_run, 0);
        pwrt_done = 1'b1;
        measure(n, c3, ri);
        if (mode <= 3) begin
            lo = lo_bound(mode == 3);
            check(pri_active && n >= lo && n <= lo + 12, (mode == 3) ? "R5" : "R4", n, lo);
            if (en) check(c3 == 1'b1, "R3", c3, 1);
            else    check(ri == 1'b0, "R7", ri, 0);
        end else begin
            check(pri_active && n <= 8, "R6", n, 8);
        end
    endtask

    initial begin
        int n; bit c3; bit ri; bit saw; int lo;
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 2; e++) begin
                run_case(m, e[0]);
            end
        end

        cfg_mode = 3'd2; cfg_en = 1'b1;
        do_reset();
        check(int_freq_sel == 3'd0, "R9", int_freq_sel, 0);
        ircf_wdata = 3'd5; ircf_wr = 1'b1; tick(); ircf_wr = 1'b0; tick();
        check(int_freq_sel == 3'd5, "R9", int_freq_sel, 5);
        pwrt_done = 1'b1;
        repeat (3) tick();
        check(cpu_run && !pri_active, "R3", {cpu_run, pri_active}, 2);
        cfg_en = 1'b0; cfg_mode = 3'd4;
        repeat (2) tick();
        check(cpu_run && !pri_active, "R12", {cpu_run, pri_active}, 2);
        cfg_en = 1'b1; cfg_mode = 3'd2;
        sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        saw = 1'b0;
        repeat (40) begin
            tick();
            if (pri_active) saw = 1'b1;
        end
        check(!saw && !cpu_run, "R8", {saw, cpu_run}, 0);
        wake_evt = 1'b1; tick(); wake_evt = 1'b0;
        measure(n, c3, ri);
        lo = lo_bound(1'b0);
        check(pri_active && (n + 1) >= lo && (n + 1) <= lo + 12, "R11", n + 1, lo);
        check(ri == 1'b1, "R11", ri, 1);
        check(int_freq_sel == 3'd5, "R9", int_freq_sel, 5);
        sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        repeat (10) tick();
        check(!cpu_run && !pri_active, "R8", {cpu_run, pri_active}, 0);
        do_reset();
        check(int_freq_sel == 3'd0, "R9", int_freq_sel, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge int_clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule